// File: doc/BRIEF.md
# Five-Lane 30-Bit Pixel Serializer

This block turns one parallel pixel into bit slots for five serial data lanes and a clock lane. A pixel holds 10 bits each of red, green and blue and four control bits: horizontal sync, vertical sync, data enable and one auxiliary bit. Each pixel period is seven slots long. A one-cycle slot strobe, supplied at seven times the pixel rate, moves every lane on by one slot. The block takes in a new pixel only on the strobe that ends slot 6.

A static select input picks one of two bit-to-slot layouts. In the low-order-first layout, lanes 0 to 2 carry colour bits 5..0 and lanes 3 and 4 carry bits 7..6 and 9..8. In the high-order-first layout, lanes 0 to 2 carry colour bits 9..4 and lanes 3 and 4 carry bits 3..2 and 1..0. This keeps the older 24-bit receivers' view of the upper bits intact on the first four lanes. The differential drivers and the slot-rate clock generation sit outside the block.

Top module: `lvds30_serializer`

## Requirements
- R1: While rst_n is low, lane_data and lane_clk are 0, and the slot index is 0. Both outputs stay 0 after reset is released until the first strobe.
- R2: The slot index moves on only on a clock edge with slot_en high, counting 0,1,...,6,0. On an edge with slot_en low, lane_data and lane_clk do not change.
- R3: pix_ready is high exactly when slot_en is high and the current slot is 6. On that edge the pixel inputs are captured. lane_data then shows slot 0 of the captured pixel, and after each later strobe it shows slots 1 to 6.
- R4: After a strobe that enters slot s, lane_clk is 1 for s = 0, 1, 5 and 6, and 0 for s = 2, 3 and 4.
- R5: With map_sel = 1 (high-order-first), slots 0..6 carry the following bits. Lane 0: G4,R9,R8,R7,R6,R5,R4. Lane 1: B5,B4,G9,G8,G7,G6,G5. Lane 2: C2,C1,C0,B9,B8,B7,B6. Lane 3: C3,B3,B2,G3,G2,R3,R2. Lane 4: C3,B1,B0,G1,G0,R1,R0. Lane n is bit n of lane_data.
- R6: With map_sel = 0 (low-order-first), slots 0..6 carry the following bits. Lane 0: G0,R5..R0. Lane 1: B1,B0,G5..G1. Lane 2: C2,C1,C0,B5..B2. Lane 3: C3,B7,B6,G7,G6,R7,R6. Lane 4: C3,B9,B8,G9,G8,R9,R8.
- R7: C0 is pix_hsync, C1 is pix_vsync, C2 is pix_de and C3 is pix_aux. In slot 0, lanes 3 and 4 both carry C3.
- R8: map_sel is used only on the capturing strobe. Changing it during a pixel period leaves that pixel's slots unchanged.
- R9: If pix_valid is low on the capturing strobe, every data lane carries 0 for all seven slots of that period. lane_clk keeps its pattern.
- R10: Changes on the colour and control inputs outside the capturing strobe have no effect on the pixel being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | Slot strobe, one per slot |
| map_sel | input | 1 | 1 = high-order-first layout, 0 = low-order-first layout |
| pix_red | input | 10 | Red component |
| pix_green | input | 10 | Green component |
| pix_blue | input | 10 | Blue component |
| pix_hsync | input | 1 | Horizontal sync (C0) |
| pix_vsync | input | 1 | Vertical sync (C1) |
| pix_de | input | 1 | Data enable (C2) |
| pix_aux | input | 1 | Auxiliary control (C3) |
| pix_valid | input | 1 | Pixel inputs hold a real pixel |
| pix_ready | output | 1 | Pixel captured on this edge |
| lane_data | output | 5 | Serial data lanes, bit n = lane n |
| lane_clk | output | 1 | Clock-lane slot value |

## Verification
The assertions assume that slot_en is a clean synchronous strobe. They also assume that a pixel source holds its inputs steady in the cycle where pix_ready is high. They place no limit on the gap between strobes. The stimulus drives every input on the falling clock edge. It inserts an idle cycle after each strobe, so the strobes are never back to back. In the middle of every pixel period it scrambles map_sel and all pixel inputs, and it still expects the slots of the captured pixel.

// File: rtl/lvds30_pkg.sv
package lvds30_pkg;
  localparam int COLOR_W = 10;
  localparam int CTL_W   = 4;
  localparam int LANES   = 5;
  localparam int SLOTS   = 7;
  localparam int SLOT_W  = $clog2(SLOTS);

  // bit offsets of each layout
  localparam int HI_FIRST_BASE   = 4;
  localparam int LO_FIRST_BASE   = 0;
  localparam int HI_FIRST_PAIR3  = 2;
  localparam int HI_FIRST_PAIR4  = 0;
  localparam int LO_FIRST_PAIR3  = 6;
  localparam int LO_FIRST_PAIR4  = 8;

  typedef enum logic {
    MAP_LO_FIRST = 1'b0,
    MAP_HI_FIRST = 1'b1
  } map_mode_e;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
    logic [CTL_W-1:0]   ctl;   // [0] hsync, [1] vsync, [2] de, [3] aux
  } pixel_t;

  typedef logic [SLOTS-1:0] lane_word_t; // bit s = slot s

  // clock lane: high at both ends of the pixel, low in slots 2..4
  function automatic logic clk_slot(input logic [SLOT_W-1:0] s);
    return (s < SLOT_W'(2)) || (s > SLOT_W'(4));
  endfunction

  // slot contents of one lane for one pixel
  function automatic lane_word_t map_lane(input map_mode_e m, input int lane,
                                          input pixel_t p);
    lane_word_t w;
    int k;
    int pb;
    w = '0;
    k = (m == MAP_HI_FIRST) ? HI_FIRST_BASE : LO_FIRST_BASE;
    case (lane)
      0: begin
        w[0] = p.green[k];
        for (int s = 1; s < SLOTS; s++) w[s] = p.red[k + 6 - s];
      end
      1: begin
        w[0] = p.blue[k + 1];
        w[1] = p.blue[k];
        for (int s = 2; s < SLOTS; s++) w[s] = p.green[k + 7 - s];
      end
      2: begin
        w[0] = p.ctl[2];
        w[1] = p.ctl[1];
        w[2] = p.ctl[0];
        for (int s = 3; s < SLOTS; s++) w[s] = p.blue[k + 8 - s];
      end
      default: begin
        if (lane == 3) pb = (m == MAP_HI_FIRST) ? HI_FIRST_PAIR3 : LO_FIRST_PAIR3;
        else           pb = (m == MAP_HI_FIRST) ? HI_FIRST_PAIR4 : LO_FIRST_PAIR4;
        w[0] = p.ctl[3];
        w[1] = p.blue[pb + 1];
        w[2] = p.blue[pb];
        w[3] = p.green[pb + 1];
        w[4] = p.green[pb];
        w[5] = p.red[pb + 1];
        w[6] = p.red[pb];
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/lvds30_slot_counter.sv
module lvds30_slot_counter #(
  parameter int SLOTS = 7,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_next,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic at_last;
  assign at_last   = (slot_q == LAST);
  assign wrap      = slot_en && at_last;
  assign slot_next = at_last ? '0 : slot_q + SLOT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (slot_en) slot_q <= slot_next;
  end

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot_q == LAST) |=> slot_q == '0);
  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(slot_q));
endmodule

// File: rtl/lvds30_pixel_mapper.sv
module lvds30_pixel_mapper
  import lvds30_pkg::*;
#(
  parameter int LANES = 5,
  parameter int SLOTS = 7
) (
  input  lvds30_pkg::pixel_t              pix,
  input  logic                            pix_valid,
  input  lvds30_pkg::map_mode_e           mode,
  output logic [LANES-1:0][SLOTS-1:0]     words
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_word_t w;
    assign w        = map_lane(mode, g, pix);
    assign words[g] = pix_valid ? SLOTS'(w) : '0;
  end
endmodule

// File: rtl/lvds30_lane_driver.sv
module lvds30_lane_driver
  import lvds30_pkg::*;
#(
  parameter int LANES = 5,
  parameter int SLOTS = 7,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot_en,
  input  logic                        wrap,
  input  logic [SLOT_W-1:0]           slot_next,
  input  logic [LANES-1:0][SLOTS-1:0] new_words,
  output logic [LANES-1:0]            lane_q,
  output logic                        clk_q
);
  logic [LANES-1:0][SLOTS-1:0] frame_q;
  logic [LANES-1:0][SLOTS-1:0] src;
  logic [LANES-1:0]            slot_bits;

  assign src = wrap ? new_words : frame_q;

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign slot_bits[g] = src[g][slot_next];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      lane_q  <= '0;
      clk_q   <= 1'b0;
    end else if (slot_en) begin
      if (wrap) frame_q <= new_words;
      lane_q <= slot_bits;
      clk_q  <= clk_slot(slot_next);
    end
  end

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(frame_q));
  assert_lane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> ($stable(lane_q) && $stable(clk_q)));
endmodule

// File: rtl/lvds30_serializer.sv
module lvds30_serializer
  import lvds30_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slot_en,
  input  logic                       map_sel,
  input  logic [COLOR_W-1:0]         pix_red,
  input  logic [COLOR_W-1:0]         pix_green,
  input  logic [COLOR_W-1:0]         pix_blue,
  input  logic                       pix_hsync,
  input  logic                       pix_vsync,
  input  logic                       pix_de,
  input  logic                       pix_aux,
  input  logic                       pix_valid,
  output logic                       pix_ready,
  output logic [LANES-1:0]           lane_data,
  output logic                       lane_clk
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0]           slot_q;
  logic [SLOT_W-1:0]           slot_next;
  logic                        wrap;
  pixel_t                      pix;
  logic [LANES-1:0][SLOTS-1:0] words;

  assign pix.red   = pix_red;
  assign pix.green = pix_green;
  assign pix.blue  = pix_blue;
  assign pix.ctl   = {pix_aux, pix_de, pix_vsync, pix_hsync};
  assign pix_ready = wrap;

  lvds30_slot_counter #(.SLOTS(SLOTS)) u_count (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
    .slot_q(slot_q), .slot_next(slot_next), .wrap(wrap)
  );

  lvds30_pixel_mapper #(.LANES(LANES), .SLOTS(SLOTS)) u_map (
    .pix(pix), .pix_valid(pix_valid), .mode(map_mode_e'(map_sel)),
    .words(words)
  );

  lvds30_lane_driver #(.LANES(LANES), .SLOTS(SLOTS)) u_drive (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .wrap(wrap),
    .slot_next(slot_next), .new_words(words),
    .lane_q(lane_data), .clk_q(lane_clk)
  );

  assert_ready_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (slot_en && slot_q == LAST));
  assert_clk_low_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot_next >= SLOT_W'(2) && slot_next <= SLOT_W'(4)) |=> !lane_clk);
  assert_clk_high_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && (slot_next < SLOT_W'(2) || slot_next > SLOT_W'(4))) |=> lane_clk);
  assert_ctl3_dup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && wrap) |=> (lane_data[3] == lane_data[4]));
  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !pix_valid) |=> (lane_data == '0));
endmodule

// File: tb/tb_lvds30_serializer.sv
module tb_lvds30_serializer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_en = 1'b0;
  logic       map_sel = 1'b0;
  logic [9:0] pix_red = '0, pix_green = '0, pix_blue = '0;
  logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0, pix_aux = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [4:0] lane_data;
  logic       lane_clk;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds30_serializer dut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .map_sel(map_sel),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
    .pix_aux(pix_aux), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected lane slots, slot 0 in the MSB of each 7-bit word
  function automatic logic [6:0] exp_lane(input logic hi, input int lane,
      input logic [9:0] r, input logic [9:0] g, input logic [9:0] b, input logic [3:0] c);
    if (hi) begin
      case (lane)
        0: return {g[4], r[9], r[8], r[7], r[6], r[5], r[4]};
        1: return {b[5], b[4], g[9], g[8], g[7], g[6], g[5]};
        2: return {c[2], c[1], c[0], b[9], b[8], b[7], b[6]};
        3: return {c[3], b[3], b[2], g[3], g[2], r[3], r[2]};
        default: return {c[3], b[1], b[0], g[1], g[0], r[1], r[0]};
      endcase
    end else begin
      case (lane)
        0: return {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
        1: return {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
        2: return {c[2], c[1], c[0], b[5], b[4], b[3], b[2]};
        3: return {c[3], b[7], b[6], g[7], g[6], r[7], r[6]};
        default: return {c[3], b[9], b[8], g[9], g[8], r[9], r[8]};
      endcase
    end
  endfunction

  function automatic logic exp_clk(input int s);
    return (s == 0) || (s == 1) || (s == 5) || (s == 6);
  endfunction

  task automatic send_pixel(input logic hi, input logic [9:0] r, input logic [9:0] g,
                            input logic [9:0] b, input logic [3:0] c, input logic valid);
    string rq;
    rq = valid ? (hi ? "R5/R7" : "R6/R7") : "R9";
    for (int s = 0; s < 7; s++) begin
      if (s == 0) begin
        map_sel = hi; pix_red = r; pix_green = g; pix_blue = b;
        {pix_aux, pix_de, pix_vsync, pix_hsync} = c; pix_valid = valid;
      end
      if (s == 3) begin
        // R8 R10: scramble everything mid-pixel
        map_sel = ~hi; pix_red = ~r; pix_green = ~g; pix_blue = ~b;
        {pix_aux, pix_de, pix_vsync, pix_hsync} = ~c; pix_valid = ~valid;
      end
      slot_en = 1'b1;
      #1;
      check("R3 ready", {31'd0, pix_ready}, {31'd0, s == 0});
      @(negedge clk);
      slot_en = 1'b0;
      for (int l = 0; l < 5; l++) begin
        logic e;
        e = valid ? exp_lane(hi, l, r, g, b, c)[6 - s] : 1'b0;
        check(s > 3 ? "R8/R10 data" : rq, {31'd0, lane_data[l]}, {31'd0, e});
      end
      check("R4 clk", {31'd0, lane_clk}, {31'd0, exp_clk(s)});
      begin
        logic [4:0] held;
        logic       heldc;
        held = lane_data; heldc = lane_clk;
        @(negedge clk);
        check("R2 hold", {26'd0, lane_clk, lane_data}, {26'd0, heldc, held});
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset lanes", {26'd0, lane_clk, lane_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {26'd0, lane_clk, lane_data}, 32'd0);
    check("R1 ready idle", {31'd0, pix_ready}, 32'd0);
    // lead-in: slots 1..6 of the reset frame
    for (int s = 1; s < 7; s++) begin
      slot_en = 1'b1;
      #1;
      check("R3 no ready", {31'd0, pix_ready}, 32'd0);
      @(negedge clk);
      slot_en = 1'b0;
      check("R1 empty frame", {27'd0, lane_data}, 32'd0);
      check("R4 clk lead-in", {31'd0, lane_clk}, {31'd0, exp_clk(s)});
      @(negedge clk);
    end
    for (int m = 0; m < 2; m++) begin
      // walking one over all 34 pixel bits
      for (int k = 0; k < 34; k++) begin
        logic [33:0] v;
        v = 34'd1 << k;
        send_pixel(m[0], v[9:0], v[19:10], v[29:20], v[33:30], 1'b1);
      end
      // walking zero and arithmetic patterns
      for (int k = 0; k < 34; k += 5) begin
        logic [33:0] v;
        v = ~(34'd1 << k);
        send_pixel(m[0], v[9:0], v[19:10], v[29:20], v[33:30], 1'b1);
      end
      for (int k = 1; k < 9; k++) begin
        send_pixel(m[0], 10'(k * 93), 10'(k * 211 + 5), 10'(k * 377 + 9), 4'(k * 3), 1'b1);
      end
      send_pixel(m[0], '1, '1, '1, '1, 1'b0);   // R9 blank with busy inputs
      send_pixel(m[0], '1, '1, '1, '1, 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule